// File: doc/BRIEF.md
# PHY Discovery and Autonegotiation Sequencer

This block brings an Ethernet transceiver up after power-on without software involvement. It sits above a management-bus (MDIO) master and drives it through a simple request handshake. On a start pulse it walks every management address from the lowest to the highest. At each address it reads both identifier registers and joins them into a 32-bit identity. That identity is compared against a parameterised list of supported parts, and the walk stops at the first address that matches.

With a transceiver found, the sequencer issues a soft reset and polls the control register until the reset bit self-clears. It then enables and restarts autonegotiation, and polls the status register until negotiation reports complete. Each poll is separated by a delay built from a tick counter, and each poll loop has its own attempt limit. At the end the block pulses a done strobe and holds its results until the next start. The results are a success flag, a failure code, the address found, the identity seen and the last status word read.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, `busy`, `done`, `success`, `mdio_start` are 0 and `fail_code` is 0.
- R2: A one-cycle `go` while idle starts one run and raises `busy`. A `go` while busy is ignored: it starts no second run, adds no extra `done` and issues no extra requests.
- R3: The scan visits addresses in ascending order from 0. At each address it reads register 2 and then register 3. `mdio_start` is a one-cycle pulse, issued only when `mdio_busy` was low. The next request waits for `mdio_done` of the previous one, so at most one request is in flight.
- R4: The identity is register 2 in bits 31:16 and register 3 in bits 15:0. It must equal an entry of `SUPPORTED_IDS` exactly, where entry i is bits [32*i+31:32*i]. The scan stops at the first matching address and reads no higher address.
- R5: If no address matches after address 31, the run ends with `fail_code`=1 and `success`=0. `found_id` holds the identity read at address 31, and no write is issued.
- R6: After a match, the block writes register 0 at the found address with 16'h8000 (bit 15 reset). It then reads register 0 until bit 15 reads 0. The first read follows the write with no delay.
- R7: At most `RESET_POLLS` control reads are made. If bit 15 is still 1 on the last one, the run ends with `fail_code`=2 and no further write. A clear bit on exactly the last read continues the sequence.
- R8: After the reset clears, the block writes register 0 with 16'h1200 (bit 12 enable, bit 9 restart). It then reads register 1 until bit 5 (negotiation complete) is 1.
- R9: At most `ANEG_POLLS` status reads are made. If bit 5 is still 0 on the last one, the run ends with `fail_code`=3. Completion on exactly the last read succeeds.
- R10: Between a poll read that fails its test and the next poll read, the block waits `DELAY_TICKS` extra cycles. Scan reads and the first poll after each write are not delayed.
- R11: `done` pulses for one cycle at the end of a run. On success, `success`=1, `fail_code`=0 and `found_addr`/`found_id` name the transceiver. `final_status` holds the last status word read, or 0 if none was read. All results hold until the next accepted `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start pulse for one bring-up run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| success | output | 1 | Last run brought the transceiver up |
| fail_code | output | 2 | 0 none, 1 no supported part, 2 reset stuck, 3 negotiation timeout |
| found_addr | output | 5 | Management address of the match (last scanned on failure) |
| found_id | output | 32 | Identity read at `found_addr` |
| final_status | output | 16 | Last status register value read |
| mdio_start | output | 1 | Request pulse to the MDIO master |
| mdio_write | output | 1 | 1 write, 0 read |
| mdio_phy_addr | output | 5 | Management address of the request |
| mdio_reg | output | 5 | Register number of the request |
| mdio_wdata | output | 16 | Write data |
| mdio_busy | input | 1 | MDIO master is working |
| mdio_done | input | 1 | One-cycle completion from the master, read data valid |
| mdio_rdata | input | 16 | Read data |

## Verification
The bench builds the block with `DELAY_TICKS`=5, `RESET_POLLS`=4 and `ANEG_POLLS`=6, and with two supported identities. These values replace the 10 ms delay and the 500 and 5000 attempt limits. Both timeout paths then finish within a few hundred cycles. Completion on exactly the last permitted attempt can also be reached and told apart from a timeout. A full 32-address scan with no match stays short, and the extra delay cycles stand clearly above the plain request spacing.

// File: rtl/phy_bringup_pkg.sv
// Shared constants and types for the transceiver bring-up sequencer.
// Assumes the standard management register layout for control/status/ID.
package phy_bringup_pkg;

    localparam int REG_W = 5;
    localparam int DATA_W = 16;

    localparam logic [REG_W-1:0] REG_CTRL  = 5'd0;
    localparam logic [REG_W-1:0] REG_STAT  = 5'd1;
    localparam logic [REG_W-1:0] REG_ID_HI = 5'd2;
    localparam logic [REG_W-1:0] REG_ID_LO = 5'd3;

    localparam int CTRL_RESET_BIT   = 15;
    localparam int CTRL_AN_EN_BIT   = 12;
    localparam int CTRL_AN_RSTRT_BIT = 9;
    localparam int STAT_AN_DONE_BIT = 5;

    localparam logic [DATA_W-1:0] CTRL_RESET_WORD = DATA_W'(1) << CTRL_RESET_BIT;
    localparam logic [DATA_W-1:0] CTRL_AN_WORD =
        (DATA_W'(1) << CTRL_AN_EN_BIT) | (DATA_W'(1) << CTRL_AN_RSTRT_BIT);

    typedef enum logic [1:0] {
        FAIL_NONE   = 2'd0,
        FAIL_NO_PHY = 2'd1,
        FAIL_RESET  = 2'd2,
        FAIL_ANEG   = 2'd3
    } fail_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_EVAL,
        ST_DELAY,
        ST_FIN
    } state_t;

    typedef enum logic [2:0] {
        PH_ID_HI,
        PH_ID_LO,
        PH_RST_WR,
        PH_RST_RD,
        PH_AN_WR,
        PH_AN_RD
    } phase_t;

endpackage

// File: rtl/phy_id_match.sv
// Compares one 32-bit identity against a parameterised list of supported
// identities. Purely combinational; entry i sits at bits [32*i +: 32].
module phy_id_match #(
    parameter int NUM_IDS = 2,
    parameter logic [NUM_IDS*32-1:0] ID_LIST = {32'h0007_C0F1, 32'h0022_1556}
) (
    input  logic [31:0] id_in,
    output logic        hit
);

    logic [NUM_IDS-1:0] hit_vec;

    // One comparator per supported identity
    for (genvar i = 0; i < NUM_IDS; i++) begin : g_cmp
        assign hit_vec[i] = (id_in == ID_LIST[i*32 +: 32]);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/phy_delay_timer.sv
// One-shot delay between poll attempts. A start pulse arms the counter; the
// expired strobe rises for one cycle TICKS cycles later. Assumes TICKS >= 1
// and that start is not raised again while a delay is running.
module phy_delay_timer #(
    parameter int TICKS = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);

    localparam int TW = $clog2(TICKS + 1);

    logic [TW-1:0] cnt_q;
    logic          run_q;

    // Load on start, count down while running, stop on the final tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= TW'(TICKS);
            run_q <= 1'b1;
        end else if (run_q) begin
            cnt_q <= cnt_q - TW'(1);
            if (cnt_q == TW'(1)) begin
                run_q <= 1'b0;
            end
        end
    end

    assign expired = run_q && (cnt_q == TW'(1));

    // R10
    no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !run_q);

endmodule

// File: rtl/phy_poll_counter.sv
// Counts failed poll attempts of one wait loop. 'last' is high when the
// attempt now being judged is the final one allowed. Assumes step is only
// raised for a failed attempt that is not the last.
module phy_poll_counter #(
    parameter int MAX_POLLS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);

    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt_q;

    // Clear at run start, advance on each failed non-final attempt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign last = (cnt_q == CW'(MAX_POLLS - 1));

    // R7, R9
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !last);

    // R7, R9
    poll_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MAX_POLLS));

endmodule

// File: rtl/phy_bringup_fsm.sv
// Control sequencer: address scan, soft reset wait, autonegotiation wait.
// Issues one management request at a time through a start/done handshake
// and holds the run results until the next accepted go. Assumes the MDIO
// master raises done for exactly one cycle per request.
module phy_bringup_fsm
    import phy_bringup_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    // helpers
    input  logic              id_hit,
    input  logic              rst_last,
    input  logic              an_last,
    input  logic              dly_expired,
    output logic [31:0]       id_cur,
    output logic              poll_clear,
    output logic              rst_step,
    output logic              an_step,
    output logic              dly_start,
    // results
    output logic              busy,
    output logic              done,
    output logic              success,
    output logic [1:0]        fail_code,
    output logic [ADDR_W-1:0] found_addr,
    output logic [15:0]       final_status,
    // MDIO master
    output logic              mdio_start,
    output logic              mdio_write,
    output logic [ADDR_W-1:0] mdio_phy_addr,
    output logic [REG_W-1:0]  mdio_reg,
    output logic [15:0]       mdio_wdata,
    input  logic              mdio_busy,
    input  logic              mdio_done,
    input  logic [15:0]       mdio_rdata
);

    localparam int NUM_ADDR = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_ADDR - 1);

    state_t            state_q;
    phase_t            phase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       id_q;
    logic [15:0]       status_q;
    logic              rst_set_q;
    logic              an_ok_q;
    fail_t             code_q;
    logic              success_q;
    logic              done_q;
    logic              start_q;
    logic              dly_q;

    // Main sequencing process: scan, reset wait, negotiation wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            phase_q   <= PH_ID_HI;
            addr_q    <= '0;
            id_q      <= '0;
            status_q  <= '0;
            rst_set_q <= 1'b0;
            an_ok_q   <= 1'b0;
            code_q    <= FAIL_NONE;
            success_q <= 1'b0;
            done_q    <= 1'b0;
            start_q   <= 1'b0;
            dly_q     <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            start_q <= 1'b0;
            dly_q   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        state_q   <= ST_REQ;
                        phase_q   <= PH_ID_HI;
                        addr_q    <= '0;
                        id_q      <= '0;
                        status_q  <= '0;
                        code_q    <= FAIL_NONE;
                        success_q <= 1'b0;
                    end
                end
                ST_REQ: begin
                    if (!mdio_busy) begin
                        start_q <= 1'b1;
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mdio_done) begin
                        state_q   <= ST_EVAL;
                        rst_set_q <= mdio_rdata[CTRL_RESET_BIT];
                        an_ok_q   <= mdio_rdata[STAT_AN_DONE_BIT];
                        if (phase_q == PH_ID_HI) id_q[31:16] <= mdio_rdata;
                        if (phase_q == PH_ID_LO) id_q[15:0]  <= mdio_rdata;
                        if (phase_q == PH_AN_RD) status_q    <= mdio_rdata;
                    end
                end
                ST_EVAL: begin
                    case (phase_q)
                        PH_ID_HI: begin
                            phase_q <= PH_ID_LO;
                            state_q <= ST_REQ;
                        end
                        PH_ID_LO: begin
                            if (id_hit) begin
                                phase_q <= PH_RST_WR;
                                state_q <= ST_REQ;
                            end else if (addr_q == LAST_ADDR) begin
                                code_q  <= FAIL_NO_PHY;
                                state_q <= ST_FIN;
                            end else begin
                                addr_q  <= addr_q + ADDR_W'(1);
                                phase_q <= PH_ID_HI;
                                state_q <= ST_REQ;
                            end
                        end
                        PH_RST_WR: begin
                            phase_q <= PH_RST_RD;
                            state_q <= ST_REQ;
                        end
                        PH_RST_RD: begin
                            if (!rst_set_q) begin
                                phase_q <= PH_AN_WR;
                                state_q <= ST_REQ;
                            end else if (rst_last) begin
                                code_q  <= FAIL_RESET;
                                state_q <= ST_FIN;
                            end else begin
                                dly_q   <= 1'b1;
                                state_q <= ST_DELAY;
                            end
                        end
                        PH_AN_WR: begin
                            phase_q <= PH_AN_RD;
                            state_q <= ST_REQ;
                        end
                        PH_AN_RD: begin
                            if (an_ok_q) begin
                                state_q <= ST_FIN;
                            end else if (an_last) begin
                                code_q  <= FAIL_ANEG;
                                state_q <= ST_FIN;
                            end else begin
                                dly_q   <= 1'b1;
                                state_q <= ST_DELAY;
                            end
                        end
                        default: state_q <= ST_FIN;
                    endcase
                end
                ST_DELAY: begin
                    if (dly_expired) state_q <= ST_REQ;
                end
                ST_FIN: begin
                    done_q    <= 1'b1;
                    success_q <= (code_q == FAIL_NONE);
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Request fields follow the current phase and scan address
    always_comb begin
        mdio_write = 1'b0;
        mdio_wdata = '0;
        case (phase_q)
            PH_ID_HI:  mdio_reg = REG_ID_HI;
            PH_ID_LO:  mdio_reg = REG_ID_LO;
            PH_RST_WR: begin
                mdio_reg   = REG_CTRL;
                mdio_write = 1'b1;
                mdio_wdata = CTRL_RESET_WORD;
            end
            PH_RST_RD: mdio_reg = REG_CTRL;
            PH_AN_WR:  begin
                mdio_reg   = REG_CTRL;
                mdio_write = 1'b1;
                mdio_wdata = CTRL_AN_WORD;
            end
            PH_AN_RD:  mdio_reg = REG_STAT;
            default:   mdio_reg = REG_CTRL;
        endcase
    end

    // Poll counter controls derived from the evaluation step
    always_comb begin
        poll_clear = (state_q == ST_IDLE) && go;
        rst_step   = (state_q == ST_EVAL) && (phase_q == PH_RST_RD) && rst_set_q && !rst_last;
        an_step    = (state_q == ST_EVAL) && (phase_q == PH_AN_RD) && !an_ok_q && !an_last;
    end

    assign id_cur        = id_q;
    assign dly_start     = dly_q;
    assign busy          = (state_q != ST_IDLE);
    assign done          = done_q;
    assign success       = success_q;
    assign fail_code     = code_q;
    assign found_addr    = addr_q;
    assign final_status  = status_q;
    assign mdio_start    = start_q;
    assign mdio_phy_addr = addr_q;

    // R3
    req_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_start |-> !$past(mdio_busy));

    // R3
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_start |=> !mdio_start);

    // R3
    addr_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (addr_q != $past(addr_q)))
            |-> (addr_q == $past(addr_q) + ADDR_W'(1)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    success_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && success) |-> (fail_code == FAIL_NONE));

    // R2
    go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && go) |-> $stable(addr_q) || (addr_q == $past(addr_q) + ADDR_W'(1)));

endmodule

// File: rtl/phy_bringup_seq.sv
// Top of the transceiver bring-up sequencer. Wires the control sequencer
// to the identity matcher, the inter-poll delay timer and one attempt
// counter per wait loop. Assumes an MDIO master with a start/busy/done
// handshake and one request in flight at a time.
module phy_bringup_seq #(
    parameter int NUM_IDS = 2,
    parameter logic [NUM_IDS*32-1:0] SUPPORTED_IDS = {32'h0007_C0F1, 32'h0022_1556},
    parameter int DELAY_TICKS = 2_500_000,
    parameter int RESET_POLLS = 500,
    parameter int ANEG_POLLS  = 5000,
    parameter int ADDR_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    output logic              busy,
    output logic              done,
    output logic              success,
    output logic [1:0]        fail_code,
    output logic [ADDR_W-1:0] found_addr,
    output logic [31:0]       found_id,
    output logic [15:0]       final_status,
    output logic              mdio_start,
    output logic              mdio_write,
    output logic [ADDR_W-1:0] mdio_phy_addr,
    output logic [4:0]        mdio_reg,
    output logic [15:0]       mdio_wdata,
    input  logic              mdio_busy,
    input  logic              mdio_done,
    input  logic [15:0]       mdio_rdata
);

    logic [31:0] id_cur;
    logic        id_hit;
    logic        poll_clear;
    logic        rst_step;
    logic        an_step;
    logic        rst_last;
    logic        an_last;
    logic        dly_start;
    logic        dly_expired;

    phy_bringup_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (go),
        .id_hit        (id_hit),
        .rst_last      (rst_last),
        .an_last       (an_last),
        .dly_expired   (dly_expired),
        .id_cur        (id_cur),
        .poll_clear    (poll_clear),
        .rst_step      (rst_step),
        .an_step       (an_step),
        .dly_start     (dly_start),
        .busy          (busy),
        .done          (done),
        .success       (success),
        .fail_code     (fail_code),
        .found_addr    (found_addr),
        .final_status  (final_status),
        .mdio_start    (mdio_start),
        .mdio_write    (mdio_write),
        .mdio_phy_addr (mdio_phy_addr),
        .mdio_reg      (mdio_reg),
        .mdio_wdata    (mdio_wdata),
        .mdio_busy     (mdio_busy),
        .mdio_done     (mdio_done),
        .mdio_rdata    (mdio_rdata)
    );

    phy_id_match #(
        .NUM_IDS (NUM_IDS),
        .ID_LIST (SUPPORTED_IDS)
    ) u_match (
        .id_in (id_cur),
        .hit   (id_hit)
    );

    phy_delay_timer #(
        .TICKS (DELAY_TICKS)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (dly_start),
        .expired (dly_expired)
    );

    phy_poll_counter #(
        .MAX_POLLS (RESET_POLLS)
    ) u_rst_polls (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clear),
        .step  (rst_step),
        .last  (rst_last)
    );

    phy_poll_counter #(
        .MAX_POLLS (ANEG_POLLS)
    ) u_an_polls (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clear),
        .step  (an_step),
        .last  (an_last)
    );

    assign found_id = id_cur;

endmodule

// File: tb/phy_bringup_seq_tb.sv
// Directed bench: a behavioural MDIO master plus transceiver answers each
// request; one task per scenario checks its own results.
module phy_bringup_seq_tb;

    localparam int TICKS = 5;
    localparam int RPOLL = 4;
    localparam int APOLL = 6;
    localparam int LAT   = 2;
    localparam logic [31:0] ID_A = 32'h0022_1556;
    localparam logic [31:0] ID_B = 32'h0007_C0F1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        busy, done, success;
    logic [1:0]  fail_code;
    logic [4:0]  found_addr;
    logic [31:0] found_id;
    logic [15:0] final_status;
    logic        mdio_start, mdio_write;
    logic [4:0]  mdio_phy_addr, mdio_reg;
    logic [15:0] mdio_wdata;
    logic        mdio_busy = 1'b0;
    logic        mdio_done = 1'b0;
    logic [15:0] mdio_rdata = 16'h0;

    always #2 clk = ~clk;

    phy_bringup_seq #(
        .NUM_IDS       (2),
        .SUPPORTED_IDS ({ID_B, ID_A}),
        .DELAY_TICKS   (TICKS),
        .RESET_POLLS   (RPOLL),
        .ANEG_POLLS    (APOLL),
        .ADDR_W        (5)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .go (go),
        .busy (busy), .done (done), .success (success),
        .fail_code (fail_code), .found_addr (found_addr),
        .found_id (found_id), .final_status (final_status),
        .mdio_start (mdio_start), .mdio_write (mdio_write),
        .mdio_phy_addr (mdio_phy_addr), .mdio_reg (mdio_reg),
        .mdio_wdata (mdio_wdata), .mdio_busy (mdio_busy),
        .mdio_done (mdio_done), .mdio_rdata (mdio_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int done_cnt = 0;

    // transceiver model state
    logic [31:0] phy_id [32];
    int rst_cfg = 0, an_cfg = 0, rst_left = 0, an_left = 0;
    int n_req = 0;
    int last_done = 0;
    int log_wr [256], log_addr [256], log_reg [256], log_data [256], log_gap [256];

    // results of the last run
    logic        r_success;
    logic [1:0]  r_code;
    logic [4:0]  r_addr;
    logic [31:0] r_id;
    logic [15:0] r_stat;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (done) done_cnt <= done_cnt + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural MDIO master + transceiver
    initial begin
        forever begin
            @(negedge clk);
            if (mdio_start) begin
                if (n_req < 256) begin
                    log_wr[n_req]   = int'(mdio_write);
                    log_addr[n_req] = int'(mdio_phy_addr);
                    log_reg[n_req]  = int'(mdio_reg);
                    log_data[n_req] = int'(mdio_wdata);
                    log_gap[n_req]  = cyc - last_done;
                end
                n_req++;
                mdio_busy = 1'b1;
                repeat (LAT) @(negedge clk);
                mdio_rdata = 16'h0;
                if (mdio_write) begin
                    if (mdio_reg == 5'd0 && mdio_wdata[15]) rst_left = rst_cfg;
                    if (mdio_reg == 5'd0 && mdio_wdata == 16'h1200) an_left = an_cfg;
                end else begin
                    case (mdio_reg)
                        5'd0: if (rst_left > 0) begin rst_left--; mdio_rdata = 16'h9000; end
                              else mdio_rdata = 16'h1000;
                        5'd1: if (an_left > 0) begin an_left--; mdio_rdata = 16'h7809; end
                              else mdio_rdata = 16'h782D;
                        5'd2: mdio_rdata = phy_id[mdio_phy_addr][31:16];
                        5'd3: mdio_rdata = phy_id[mdio_phy_addr][15:0];
                        default: mdio_rdata = 16'h0;
                    endcase
                end
                mdio_done = 1'b1;
                last_done = cyc;
                @(negedge clk);
                mdio_done = 1'b0;
                mdio_busy = 1'b0;
            end
        end
    end

    task automatic clear_phys();
        for (int a = 0; a < 32; a++) phy_id[a] = 32'hFFFF_FFFF;
        rst_cfg = 0;
        an_cfg = 0;
    endtask

    // Pulse go, optionally pulse it again at cycle extra_at, wait for done
    task automatic run_seq(input int extra_at);
        int k;
        n_req = 0;
        @(negedge clk);
        done_cnt = 0;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        k = 0;
        while (!done && k < 20000) begin
            go = (k == extra_at);
            @(negedge clk);
            k++;
        end
        go = 1'b0;
        if (k >= 20000) chk("R11 run timeout", 32'd0, 32'd1);
        r_success = success;
        r_code    = fail_code;
        r_addr    = found_addr;
        r_id      = found_id;
        r_stat    = final_status;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 busy", {31'b0, busy}, 0);
        chk("R1 done", {31'b0, done}, 0);
        chk("R1 success", {31'b0, success}, 0);
        chk("R1 fail_code", {30'b0, fail_code}, 0);
        chk("R1 mdio_start", {31'b0, mdio_start}, 0);
    endtask

    task automatic t_basic();
        bit order_ok = 1'b1;
        clear_phys();
        phy_id[5] = ID_B;
        rst_cfg = 2;
        an_cfg = 3;
        run_seq(6);
        chk("R11 success", {31'b0, r_success}, 1);
        chk("R11 fail_code", {30'b0, r_code}, 0);
        chk("R11 found_addr", {27'b0, r_addr}, 5);
        chk("R4 found_id", r_id, ID_B);
        chk("R11 final_status", {16'b0, r_stat}, 32'h782D);
        chk("R2 request count", n_req, 21);
        for (int i = 0; i < 12; i++)
            if (log_wr[i] != 0 || log_addr[i] != i / 2 || log_reg[i] != 2 + (i % 2)) order_ok = 1'b0;
        chk("R3 scan order", {31'b0, order_ok}, 1);
        chk("R6 reset write", {log_wr[12][3:0], log_reg[12][3:0], log_addr[12][7:0], log_data[12][15:0]},
            {4'd1, 4'd0, 8'd5, 16'h8000});
        chk("R6 control poll reg", log_reg[13] + log_reg[14] + log_reg[15], 0);
        chk("R8 aneg write", {log_wr[16][7:0], log_reg[16][7:0], log_data[16][15:0]},
            {8'd1, 8'd0, 16'h1200});
        chk("R8 status poll reg", log_reg[17] + log_reg[18] + log_reg[19] + log_reg[20], 4);
        chk("R10 no delay before first poll", log_gap[13], log_gap[1]);
        chk("R10 delay between polls", {31'b0, log_gap[14] >= log_gap[1] + TICKS}, 1);
        chk("R10 delay between status polls", {31'b0, log_gap[18] >= log_gap[1] + TICKS}, 1);
        repeat (30) @(negedge clk);
        chk("R2 no extra requests", n_req, 21);
        chk("R2 single done", done_cnt, 1);
        chk("R11 results held", {27'b0, found_addr}, 5);
    endtask

    task automatic t_nophy();
        int writes = 0;
        clear_phys();
        phy_id[7] = 32'h1234_5678;
        phy_id[31] = 32'h0022_15FF;
        run_seq(-1);
        chk("R5 fail_code", {30'b0, r_code}, 1);
        chk("R5 success", {31'b0, r_success}, 0);
        chk("R5 last id", r_id, 32'h0022_15FF);
        chk("R5 request count", n_req, 64);
        for (int i = 0; i < 64; i++) writes += log_wr[i];
        chk("R5 no writes", writes, 0);
        chk("R3 last address", log_addr[63], 31);
    endtask

    task automatic t_first_match();
        int maxa = 0;
        clear_phys();
        phy_id[2] = {ID_A[31:16], 16'hFFFF};
        phy_id[3] = 32'h1234_5678;
        phy_id[9] = ID_A;
        phy_id[20] = ID_B;
        run_seq(-1);
        chk("R4 first match addr", {27'b0, r_addr}, 9);
        chk("R4 first match id", r_id, ID_A);
        chk("R4 success", {31'b0, r_success}, 1);
        chk("R4 request count", n_req, 24);
        for (int i = 0; i < 20; i++) if (log_addr[i] > maxa) maxa = log_addr[i];
        chk("R4 no higher address", maxa, 9);
    endtask

    task automatic t_rst_timeout();
        int writes = 0;
        clear_phys();
        phy_id[0] = ID_A;
        rst_cfg = 100;
        run_seq(-1);
        chk("R7 fail_code", {30'b0, r_code}, 2);
        chk("R7 success", {31'b0, r_success}, 0);
        chk("R7 request count", n_req, 2 + 1 + RPOLL);
        for (int i = 0; i < n_req; i++) writes += log_wr[i];
        chk("R7 single write", writes, 1);
        chk("R11 status never read", {16'b0, r_stat}, 0);
    endtask

    task automatic t_rst_last();
        clear_phys();
        phy_id[0] = ID_B;
        rst_cfg = RPOLL - 1;
        run_seq(-1);
        chk("R7 clear on last poll", {31'b0, r_success}, 1);
        chk("R7 last poll count", n_req, 2 + 1 + RPOLL + 1 + 1);
    endtask

    task automatic t_an_timeout();
        clear_phys();
        phy_id[1] = ID_A;
        rst_cfg = 0;
        an_cfg = 100;
        run_seq(-1);
        chk("R9 fail_code", {30'b0, r_code}, 3);
        chk("R9 final_status", {16'b0, r_stat}, 32'h7809);
        chk("R9 request count", n_req, 4 + 1 + 1 + 1 + APOLL);
        repeat (10) @(negedge clk);
        chk("R11 code held", {30'b0, fail_code}, 3);
    endtask

    task automatic t_an_last();
        clear_phys();
        phy_id[1] = ID_A;
        an_cfg = APOLL - 1;
        run_seq(-1);
        chk("R9 complete on last poll", {31'b0, r_success}, 1);
        chk("R9 fail_code", {30'b0, r_code}, 0);
        chk("R9 last poll count", n_req, 4 + 1 + 1 + 1 + APOLL);
        chk("R9 final_status", {16'b0, r_stat}, 32'h782D);
    endtask

    initial begin
        for (int a = 0; a < 32; a++) phy_id[a] = 32'hFFFF_FFFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_nophy();
        t_first_match();
        t_rst_timeout();
        t_rst_last();
        t_an_timeout();
        t_an_last();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule